// File: doc/BRIEF.md
# Asymmetric Dual-Clock Byte-Lane Memory

This block is a behavioural memory that two ports on separate clocks share, and the two ports see it at different widths. The narrow port runs on its own clock, carries 32-bit words and can both write and read. Each of its writes is gated by one enable bit per byte lane. The wide port runs on a second clock and only writes. It views the same bits as 128-bit words, each covering four consecutive narrow words, and it has no byte enables.

A typical use is a bulk producer that fills a buffer in wide beats, while a narrow consumer reads individual words and patches single bytes. The storage holds all zeros after power-up. The narrow port registers the read address on its own clock, so read data follows with a one-cycle latency. Two cases give no defined result: one port reading a word while the other writes it, and both ports writing the same word at the same time.

Top module: `asym_dc_ram`

## Requirements
- R1: After power-up every narrow word reads 0x00000000. While rst_ni is low the registered narrow read address is 0, so a_rdata_o shows narrow word 0.
- R2: A narrow write with a_be_i = 4'b1111 stores a_wdata_i at a_addr_i. a_rdata_o shows the word whose address was presented at the previous clk_a_i rising edge, and a write takes effect at that same edge. A change of a_addr_i alone does not change a_rdata_o before the next edge.
- R3: During a narrow write, a_be_i bit l controls bits [8l+7:8l] of the word. Lanes whose enable bit is low keep their old contents.
- R4: A narrow write with a_be_i = 4'b0000 leaves the memory unchanged.
- R5: Wide word k holds narrow words 4k+s for s = 0..3. Narrow word 4k+s maps to bits [32s+31:32s] of the wide word, with narrow word 4k in the low 32 bits.
- R6: A wide write replaces all 32 bits of each of its four narrow words. This includes values written earlier from the narrow port. A later narrow byte write modifies only its own lane of data that a wide write placed there.
- R7: The mapping holds at the array edges: wide words 0 and 63, and narrow words 0 and 255.
- R8: Narrow reads (a_we_i low) never alter stored data. Repeated reads of one address return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Narrow port clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the narrow read address register |
| a_we_i | input | 1 | Narrow write strobe |
| a_be_i | input | 4 | Narrow byte-lane write enables, bit l for bits [8l+7:8l] |
| a_addr_i | input | 8 | Narrow word address |
| a_wdata_i | input | 32 | Narrow write data |
| a_rdata_o | output | 32 | Narrow read data, one cycle after the address |
| clk_b_i | input | 1 | Wide port clock |
| b_we_i | input | 1 | Wide write strobe |
| b_addr_i | input | 6 | Wide word address |
| b_wdata_i | input | 128 | Wide write data |

## Verification
Full-word narrow writes with distinct values at neighbouring addresses confirm addressing. A step of the address on consecutive cycles separates a registered read from a combinational one. Byte-enable patterns (single lanes, alternating lanes and none) over a known background show whether each enable bit reaches only its own lane. Wide writes use a different value in every 32-bit slice, and each slice is read back through the narrow port. This exposes any swap of sub-word order or lane order. Overwriting narrow data with wide data, and the reverse, shows that the two write paths resolve to the value written last.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;
  localparam int unsigned LANE_W      = 8;
  localparam int unsigned DEF_A_DW    = 32;
  localparam int unsigned DEF_A_DEPTH = 256;
  localparam int unsigned DEF_RATIO   = 4;
endpackage

// File: rtl/asym_ram_rd_addr.sv
module asym_ram_rd_addr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else         addr_o <= addr_i;
  end
endmodule

// File: rtl/asym_ram_lane.sv
// One byte lane of the shared array. Each port owns one copy; the stored
// value is the XOR of both copies, so every copy has a single writer.
module asym_ram_lane #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned RATIO = 4,
  parameter int unsigned LW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned SW   = $clog2(RATIO),
  localparam int unsigned BAW  = AW - SW
) (
  input  logic                clk_a_i,
  input  logic                we_a_i,
  input  logic [AW-1:0]       addr_a_i,
  input  logic [LW-1:0]       wdata_a_i,
  input  logic                clk_b_i,
  input  logic                we_b_i,
  input  logic [BAW-1:0]      addr_b_i,
  input  logic [RATIO*LW-1:0] wdata_b_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [LW-1:0]       rd_data_o
);
  logic [LW-1:0] copy_a [DEPTH];
  logic [LW-1:0] copy_b [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      copy_a[i] = '0;
      copy_b[i] = '0;
    end
  end

  always_ff @(posedge clk_a_i) begin
    if (we_a_i) copy_a[addr_a_i] <= wdata_a_i ^ copy_b[addr_a_i];
  end

  always_ff @(posedge clk_b_i) begin
    if (we_b_i) begin
      for (int s = 0; s < RATIO; s++) begin
        copy_b[{addr_b_i, SW'(s)}] <= wdata_b_i[s*LW +: LW] ^ copy_a[{addr_b_i, SW'(s)}];
      end
    end
  end

  assign rd_data_o = copy_a[rd_addr_i] ^ copy_b[rd_addr_i];
endmodule

// File: rtl/asym_dc_ram.sv
module asym_dc_ram
  import asym_ram_pkg::*;
#(
  parameter int unsigned A_DW    = DEF_A_DW,
  parameter int unsigned A_DEPTH = DEF_A_DEPTH,
  parameter int unsigned RATIO   = DEF_RATIO,
  localparam int unsigned LANES   = A_DW / LANE_W,
  localparam int unsigned A_AW    = $clog2(A_DEPTH),
  localparam int unsigned B_DW    = A_DW * RATIO,
  localparam int unsigned B_DEPTH = A_DEPTH / RATIO,
  localparam int unsigned B_AW    = $clog2(B_DEPTH)
) (
  input  logic             clk_a_i,
  input  logic             rst_ni,
  input  logic             a_we_i,
  input  logic [LANES-1:0] a_be_i,
  input  logic [A_AW-1:0]  a_addr_i,
  input  logic [A_DW-1:0]  a_wdata_i,
  output logic [A_DW-1:0]  a_rdata_o,
  input  logic             clk_b_i,
  input  logic             b_we_i,
  input  logic [B_AW-1:0]  b_addr_i,
  input  logic [B_DW-1:0]  b_wdata_i
);
  logic [A_AW-1:0] rd_addr_q;

  asym_ram_rd_addr #(.AW(A_AW)) u_rd_addr (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .addr_i (a_addr_i),
    .addr_o (rd_addr_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [RATIO*LANE_W-1:0] b_lane_data;
    for (genvar s = 0; s < RATIO; s++) begin : g_sub
      // sub-word s sits in wide bits [s*A_DW +: A_DW] (R5)
      assign b_lane_data[s*LANE_W +: LANE_W] = b_wdata_i[s*A_DW + l*LANE_W +: LANE_W];
    end

    asym_ram_lane #(.DEPTH(A_DEPTH), .RATIO(RATIO), .LW(LANE_W)) u_lane (
      .clk_a_i   (clk_a_i),
      .we_a_i    (a_we_i & a_be_i[l]),
      .addr_a_i  (a_addr_i),
      .wdata_a_i (a_wdata_i[l*LANE_W +: LANE_W]),
      .clk_b_i   (clk_b_i),
      .we_b_i    (b_we_i),
      .addr_b_i  (b_addr_i),
      .wdata_b_i (b_lane_data),
      .rd_addr_i (rd_addr_q),
      .rd_data_o (a_rdata_o[l*LANE_W +: LANE_W])
    );

    // Port-collision cases are undefined and excluded by use.
    a_r3_lane_write: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
      (a_we_i && a_be_i[l]) |=> a_rdata_o[l*LANE_W +: LANE_W] == $past(a_wdata_i[l*LANE_W +: LANE_W]));
  end

  a_r2_full_write: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_we_i && a_be_i == '1) |=> a_rdata_o == $past(a_wdata_i));

  a_r4_no_lane_write: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_we_i && a_be_i == '0 && a_addr_i == rd_addr_q) |=> $stable(a_rdata_o));

  a_r8_read_only: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_we_i && a_addr_i == rd_addr_q) |=> $stable(a_rdata_o));
endmodule

// File: tb/asym_dc_ram_tb_top.sv
module asym_dc_ram_tb_top;
  logic         clk_a = 1'b0;
  logic         clk_b = 1'b0;
  logic         rst_n = 1'b1;
  logic         a_we = 1'b0;
  logic [3:0]   a_be = '0;
  logic [7:0]   a_addr = '0;
  logic [31:0]  a_wdata = '0;
  logic [31:0]  a_rdata;
  logic         b_we = 1'b0;
  logic [5:0]   b_addr = '0;
  logic [127:0] b_wdata = '0;

  logic [31:0] ref_mem [256];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_a = ~clk_a;
  always #3 clk_b = ~clk_b;

  asym_dc_ram dut_i (
    .clk_a_i(clk_a), .rst_ni(rst_n), .a_we_i(a_we), .a_be_i(a_be),
    .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_rdata_o(a_rdata),
    .clk_b_i(clk_b), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic a_wr(input logic [7:0] addr, input logic [3:0] be,
                      input logic [31:0] data, input string tag);
    @(negedge clk_a);
    a_we = 1'b1; a_be = be; a_addr = addr; a_wdata = data;
    for (int l = 0; l < 4; l++)
      if (be[l]) ref_mem[addr][l*8 +: 8] = data[l*8 +: 8];
    @(negedge clk_a);
    a_we = 1'b0; a_be = '0;
    check(tag, a_rdata, ref_mem[addr]);
  endtask

  task automatic a_rd(input logic [7:0] addr, input string tag);
    @(negedge clk_a);
    a_we = 1'b0; a_addr = addr;
    @(negedge clk_a);
    check(tag, a_rdata, ref_mem[addr]);
  endtask

  task automatic b_wr(input logic [5:0] k, input logic [127:0] data, input string tag);
    @(negedge clk_a);
    a_we = 1'b0; a_addr = (k == 6'd0) ? 8'd255 : 8'd0;
    @(negedge clk_a);
    @(negedge clk_b);
    b_we = 1'b1; b_addr = k; b_wdata = data;
    @(negedge clk_b);
    b_we = 1'b0;
    for (int s = 0; s < 4; s++) ref_mem[{k, 2'(s)}] = data[s*32 +: 32];
    for (int s = 0; s < 4; s++) a_rd({k, 2'(s)}, tag);
  endtask

  task automatic t_reset_state;
    check("R1 reset rdata", a_rdata, 32'h0);
    @(negedge clk_a); rst_n = 1'b1;
    a_rd(8'd0, "R1 zero word0");
    a_rd(8'd37, "R1 zero word37");
    a_rd(8'd255, "R1 zero word255");
  endtask

  task automatic t_full_write;
    a_wr(8'd10, 4'hF, 32'hDEADBEEF, "R2 write 10");
    a_wr(8'd11, 4'hF, 32'h01234567, "R2 write 11");
    a_rd(8'd10, "R2 read 10");
    @(negedge clk_a); a_addr = 8'd11;
    check("R2 addr change alone", a_rdata, ref_mem[10]);
    @(negedge clk_a);
    check("R2 one-cycle latency", a_rdata, ref_mem[11]);
  endtask

  task automatic t_byte_lanes;
    a_wr(8'd40, 4'hF, 32'h11223344, "R3 background");
    a_wr(8'd40, 4'b0101, 32'hAABBCCDD, "R3 lanes 0,2");
    check("R3 lanes 0,2 value", a_rdata, 32'h11BB33DD);
    for (int l = 0; l < 4; l++) begin
      a_wr(8'd41, 4'hF, 32'h0, "R3 clear");
      a_wr(8'd41, 4'(1 << l), 32'hFFFFFFFF, "R3 single lane");
      check("R3 single lane value", a_rdata, 32'hFF << (8 * l));
    end
  endtask

  task automatic t_no_enable;
    a_wr(8'd40, 4'b0000, 32'h55555555, "R4 be none");
    check("R4 unchanged", a_rdata, 32'h11BB33DD);
    a_rd(8'd40, "R4 reread");
  endtask

  task automatic t_wide_write;
    b_wr(6'd10, {32'hD3D3D3D3, 32'hC2C2C2C2, 32'hB1B1B1B1, 32'hA0A0A0A0}, "R5 wide word 10");
    b_wr(6'd2, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111}, "R5 wide word 2");
  endtask

  task automatic t_overwrite;
    a_wr(8'd20, 4'hF, 32'h600DF00D, "R6 narrow seed");
    b_wr(6'd5, {32'h78787878, 32'h56565656, 32'h34343434, 32'h12121212}, "R6 wide over narrow");
    a_wr(8'd21, 4'b0010, 32'h0000EE00, "R6 lane over wide");
    check("R6 lane over wide value", a_rdata, 32'h3434EE34);
    a_rd(8'd22, "R6 neighbour untouched");
  endtask

  task automatic t_edges;
    b_wr(6'd0, {32'h0F0F0003, 32'h0F0F0002, 32'h0F0F0001, 32'h0F0F0000}, "R7 wide word 0");
    b_wr(6'd63, {32'hE0E000FF, 32'hE0E000FE, 32'hE0E000FD, 32'hE0E000FC}, "R7 wide word 63");
    a_wr(8'd255, 4'b1000, 32'h99000000, "R7 narrow 255 lane3");
    check("R7 narrow 255 value", a_rdata, 32'h99E000FF);
    a_wr(8'd0, 4'b0001, 32'h000000AB, "R7 narrow 0 lane0");
    check("R7 narrow 0 value", a_rdata, 32'h0F0F00AB);
  endtask

  task automatic t_read_only;
    for (int i = 0; i < 3; i++) a_rd(8'd10, "R8 repeated read");
    a_rd(8'd40, "R8 other addr");
    a_rd(8'd10, "R8 back");
  endtask

  task automatic t_mid_reset;
    a_rd(8'd7, "R1 pre-reset read");
    @(negedge clk_a); rst_n = 1'b0;
    #1;
    check("R1 reset shows word0", a_rdata, ref_mem[0]);
    @(negedge clk_a); rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk_a);
    t_reset_state();
    t_full_write();
    t_byte_lanes();
    t_no_enable();
    t_wide_write();
    t_overwrite();
    t_edges();
    t_read_only();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_a);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule